// File: doc/BRIEF.md
# Reorder Buffer with Register-Status Indirection

This block keeps the program order of a pipeline whose functional units finish out of order. At decode each instruction takes the next slot at the tail of a circular buffer. The block records the instruction's destination register and fault PC there. It also points that register's entry in a per-register status table at the new slot. Units that finish later write their result and a fault flag straight into their own slot, through any of several completion ports.

Source operands never search the buffer. A read looks up the status table first. If the register is settled, the value comes from the architectural register file. Otherwise the table gives the producing slot number, and that slot is read directly.

Only the oldest slot may leave the buffer. A finished, fault-free head copies its result into the architectural register file. A finished head that carries a fault does three things in one cycle: it discards every slot, resets every status entry to settled, and steers fetch to a fixed handler address while reporting the faulting PC.

Top module: `rob_rename`

## Requirements
- R1: An accepted allocation returns `alloc_id` equal to the tail slot. Consecutive accepted allocations receive consecutive slot numbers, wrapping from DEPTH-1 to 0. The first slot after reset or after a flush is 0.
- R2: When DEPTH slots are occupied, `rob_full` is 1, `alloc_ok` is 0, and a refused request changes neither the buffer nor the status table.
- R3: A completion may target any occupied slot in any order. From the next cycle, a source read of a register mapped to that slot returns `rd_ready`=1 and the completed value.
- R4: Retirement is strictly in allocation order. `ret_vld` is 1 only while the head slot is completed without a fault, and completed younger slots wait behind an unfinished head.
- R5: In a retiring cycle, `ret_dst` and `ret_data` give the head's destination and result. A nonzero destination is written to the architectural register file at that edge, and later reads return it with `rd_ready`=1.
- R6: Retirement resets a register's status to settled only if the status still points at the retiring slot. If a younger writer holds the mapping, reads keep returning `rd_ready`=0 with `rd_tag` naming the younger slot.
- R7: When the head slot is completed with its fault flag set, `flush` is 1 for that cycle, `epc` equals the head's PC, and `redirect_pc` equals HANDLER_PC. Younger slots are discarded without writing the register file.
- R8: At a flush edge, occupancy, head and tail return to zero and every register status returns to settled. Later reads give register-file contents with `rd_ready`=1.
- R9: Destination register 0 is never mapped. A read of register 0 always gives `rd_ready`=1 and value 0, even after an instruction with destination 0 retires.
- R10: A read of a register whose producer has not completed gives `rd_ready`=0, value 0, and `rd_tag` equal to the producing slot.
- R11: No allocation is accepted in a flush cycle, and a request made then leaves no mapping behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_dst | input | AREG_W | Destination register (0 means none) |
| alloc_pc | input | PC_W | PC of the instruction being allocated |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_id | output | IDX_W | Slot number given to the allocation |
| rob_full | output | 1 | All slots occupied |
| rd_areg | input | NUM_RD x AREG_W | Source register per read port |
| rd_ready | output | NUM_RD | Operand value available |
| rd_value | output | NUM_RD x DATA_W | Operand value (0 when not ready) |
| rd_tag | output | NUM_RD x IDX_W | Producing slot when mapped |
| cpl_vld | input | NUM_CPL | Completion strobe per port |
| cpl_id | input | NUM_CPL x IDX_W | Completing slot per port |
| cpl_data | input | NUM_CPL x DATA_W | Result per port |
| cpl_exc | input | NUM_CPL | Fault flag per port |
| ret_vld | output | 1 | Head retires this cycle |
| ret_dst | output | AREG_W | Destination of retiring slot |
| ret_data | output | DATA_W | Result of retiring slot |
| flush | output | 1 | Faulting head: discard everything |
| epc | output | PC_W | PC of the faulting head |
| redirect_pc | output | PC_W | Fetch target during a flush |

## Verification
The assertions assume several things about the inputs:
- `alloc_req` is low while reset is applied.
- Completion ports only name occupied slots that have not completed.
- No two ports name the same slot in one cycle.

The stimulus respects this. It drives completions only for slot numbers it has itself received from `alloc_id` and has not yet completed. It uses one completion port at a time, and it holds every request low through reset. Expected retirements are queued by the driver in program order. A monitor compares each `ret_vld` cycle against the head of that queue.

// File: rtl/rob_pkg.sv
package rob_pkg;
   // Where a source operand is taken from
   typedef enum logic [1:0] {
      SRC_ZERO     = 2'd0,
      SRC_ARCH     = 2'd1,
      SRC_BUF_DONE = 2'd2,
      SRC_BUF_WAIT = 2'd3
   } src_kind_e;
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
   parameter int DEPTH   = 8,
   parameter int AREG_W  = 4,
   parameter int DATA_W  = 32,
   parameter int PC_W    = 32,
   parameter int NUM_CPL = 2,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic                              alloc_we,
   input  logic [IDX_W-1:0]                  alloc_idx,
   input  logic [AREG_W-1:0]                 alloc_dst,
   input  logic [PC_W-1:0]                   alloc_pc,
   input  logic                              retire,
   input  logic [IDX_W-1:0]                  head_idx,
   input  logic [NUM_CPL-1:0]                cpl_vld,
   input  logic [NUM_CPL-1:0][IDX_W-1:0]     cpl_id,
   input  logic [NUM_CPL-1:0][DATA_W-1:0]    cpl_data,
   input  logic [NUM_CPL-1:0]                cpl_exc,
   output logic [DEPTH-1:0]                  ent_valid,
   output logic [DEPTH-1:0]                  ent_done,
   output logic [DEPTH-1:0]                  ent_exc,
   output logic [DEPTH-1:0][AREG_W-1:0]      ent_dst,
   output logic [DEPTH-1:0][PC_W-1:0]        ent_pc,
   output logic [DEPTH-1:0][DATA_W-1:0]      ent_data
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      localparam logic [IDX_W-1:0] SID = IDX_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_done[e]  <= 1'b0;
            ent_exc[e]   <= 1'b0;
            ent_dst[e]   <= '0;
            ent_pc[e]    <= '0;
            ent_data[e]  <= '0;
         end else if (flush) begin
            ent_valid[e] <= 1'b0;
            ent_done[e]  <= 1'b0;
            ent_exc[e]   <= 1'b0;
         end else begin
            if (retire && head_idx == SID) begin
               ent_valid[e] <= 1'b0;
               ent_done[e]  <= 1'b0;
            end
            for (int c = 0; c < NUM_CPL; c++) begin
               if (cpl_vld[c] && cpl_id[c] == SID && ent_valid[e]) begin
                  ent_done[e] <= 1'b1;
                  ent_exc[e]  <= cpl_exc[c];
                  ent_data[e] <= cpl_data[c];
               end
            end
            if (alloc_we && alloc_idx == SID) begin
               ent_valid[e] <= 1'b1;
               ent_done[e]  <= 1'b0;
               ent_exc[e]   <= 1'b0;
               ent_dst[e]   <= alloc_dst;
               ent_pc[e]    <= alloc_pc;
            end
         end
      end
   end
endmodule

// File: rtl/rob_status_table.sv
module rob_status_table #(
   parameter int DEPTH   = 8,
   parameter int AREG_W  = 4,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int NUM_AREGS = 1 << AREG_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic                              alloc_we,
   input  logic [AREG_W-1:0]                 alloc_dst,
   input  logic [IDX_W-1:0]                  alloc_idx,
   input  logic                              retire,
   input  logic [AREG_W-1:0]                 retire_dst,
   input  logic [IDX_W-1:0]                  retire_idx,
   output logic [NUM_AREGS-1:0]              st_valid,
   output logic [NUM_AREGS-1:0][IDX_W-1:0]   st_tag
);
   for (genvar r = 0; r < NUM_AREGS; r++) begin : g_reg
      if (r == 0) begin : g_zero
         // register zero is hard-wired settled
         assign st_valid[r] = 1'b1;
         assign st_tag[r]   = '0;
      end else begin : g_map
         localparam logic [AREG_W-1:0] RID = AREG_W'(r);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_valid[r] <= 1'b1;
               st_tag[r]   <= '0;
            end else if (flush) begin
               st_valid[r] <= 1'b1;
               st_tag[r]   <= '0;
            end else if (alloc_we && alloc_dst == RID) begin
               st_valid[r] <= 1'b0;
               st_tag[r]   <= alloc_idx;
            end else if (retire && retire_dst == RID && !st_valid[r]
                         && st_tag[r] == retire_idx) begin
               st_valid[r] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rob_arch_regs.sv
module rob_arch_regs #(
   parameter int AREG_W  = 4,
   parameter int DATA_W  = 32,
   localparam int NUM_AREGS = 1 << AREG_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [AREG_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_AREGS-1:0][DATA_W-1:0]   arch_q
);
   for (genvar r = 0; r < NUM_AREGS; r++) begin : g_areg
      if (r == 0) begin : g_zero
         assign arch_q[r] = '0;
      end else begin : g_store
         localparam logic [AREG_W-1:0] RID = AREG_W'(r);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        arch_q[r] <= '0;
            else if (wr_en && wr_idx == RID)   arch_q[r] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/rob_rename.sv
module rob_rename
   import rob_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int AREG_W  = 4,
   parameter int DATA_W  = 32,
   parameter int PC_W    = 32,
   parameter int NUM_RD  = 2,
   parameter int NUM_CPL = 2,
   parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int NUM_AREGS = 1 << AREG_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              alloc_req,
   input  logic [AREG_W-1:0]                 alloc_dst,
   input  logic [PC_W-1:0]                   alloc_pc,
   output logic                              alloc_ok,
   output logic [IDX_W-1:0]                  alloc_id,
   output logic                              rob_full,
   input  logic [NUM_RD-1:0][AREG_W-1:0]     rd_areg,
   output logic [NUM_RD-1:0]                 rd_ready,
   output logic [NUM_RD-1:0][DATA_W-1:0]     rd_value,
   output logic [NUM_RD-1:0][IDX_W-1:0]      rd_tag,
   input  logic [NUM_CPL-1:0]                cpl_vld,
   input  logic [NUM_CPL-1:0][IDX_W-1:0]     cpl_id,
   input  logic [NUM_CPL-1:0][DATA_W-1:0]    cpl_data,
   input  logic [NUM_CPL-1:0]                cpl_exc,
   output logic                              ret_vld,
   output logic [AREG_W-1:0]                 ret_dst,
   output logic [DATA_W-1:0]                 ret_data,
   output logic                              flush,
   output logic [PC_W-1:0]                   epc,
   output logic [PC_W-1:0]                   redirect_pc
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_rename: DEPTH must be a power of two, at least 2");
   end
   if (AREG_W < 1 || AREG_W > 8) begin : g_bad_areg
      $error("rob_rename: AREG_W out of range");
   end
   if (NUM_RD < 1 || NUM_CPL < 1) begin : g_bad_ports
      $error("rob_rename: need at least one read and one completion port");
   end

   logic [IDX_W-1:0] head, tail;
   logic [CNT_W-1:0] occ;

   logic [DEPTH-1:0]               ent_valid, ent_done, ent_exc;
   logic [DEPTH-1:0][AREG_W-1:0]   ent_dst;
   logic [DEPTH-1:0][PC_W-1:0]     ent_pc;
   logic [DEPTH-1:0][DATA_W-1:0]   ent_data;
   logic [NUM_AREGS-1:0]             st_valid;
   logic [NUM_AREGS-1:0][IDX_W-1:0]  st_tag;
   logic [NUM_AREGS-1:0][DATA_W-1:0] arch_q;

   logic head_ready, do_retire, do_flush, do_alloc;

   assign head_ready = ent_valid[head] && ent_done[head];
   assign do_flush   = head_ready && ent_exc[head];
   assign do_retire  = head_ready && !ent_exc[head];
   assign rob_full   = (occ == CNT_W'(DEPTH));
   assign do_alloc   = alloc_req && !rob_full && !do_flush;

   assign alloc_ok    = do_alloc;
   assign alloc_id    = tail;
   assign ret_vld     = do_retire;
   assign ret_dst     = ent_dst[head];
   assign ret_data    = ent_data[head];
   assign flush       = do_flush;
   assign epc         = ent_pc[head];
   assign redirect_pc = HANDLER_PC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else if (do_flush) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         if (do_alloc)  tail <= tail + 1'b1;
         if (do_retire) head <= head + 1'b1;
         occ <= occ + CNT_W'(do_alloc) - CNT_W'(do_retire);
      end
   end

   rob_entry_store #(
      .DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .PC_W(PC_W), .NUM_CPL(NUM_CPL)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .flush(do_flush),
      .alloc_we(do_alloc), .alloc_idx(tail), .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
      .retire(do_retire), .head_idx(head),
      .cpl_vld(cpl_vld), .cpl_id(cpl_id), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
      .ent_valid(ent_valid), .ent_done(ent_done), .ent_exc(ent_exc),
      .ent_dst(ent_dst), .ent_pc(ent_pc), .ent_data(ent_data)
   );

   rob_status_table #(
      .DEPTH(DEPTH), .AREG_W(AREG_W)
   ) i_status (
      .clk(clk), .rst_n(rst_n), .flush(do_flush),
      .alloc_we(do_alloc), .alloc_dst(alloc_dst), .alloc_idx(tail),
      .retire(do_retire), .retire_dst(ent_dst[head]), .retire_idx(head),
      .st_valid(st_valid), .st_tag(st_tag)
   );

   rob_arch_regs #(
      .AREG_W(AREG_W), .DATA_W(DATA_W)
   ) i_arch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(do_retire), .wr_idx(ent_dst[head]), .wr_data(ent_data[head]),
      .arch_q(arch_q)
   );

   // operand lookup: status table first, then direct slot index
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      src_kind_e        kind;
      logic [IDX_W-1:0] tag;
      assign tag = st_tag[rd_areg[p]];
      always_comb begin
         if (rd_areg[p] == '0)          kind = SRC_ZERO;
         else if (st_valid[rd_areg[p]]) kind = SRC_ARCH;
         else if (ent_done[tag])        kind = SRC_BUF_DONE;
         else                           kind = SRC_BUF_WAIT;
      end
      always_comb begin
         rd_ready[p] = 1'b1;
         rd_value[p] = '0;
         rd_tag[p]   = '0;
         unique case (kind)
            SRC_ZERO: ;
            SRC_ARCH:     rd_value[p] = arch_q[rd_areg[p]];
            SRC_BUF_DONE: begin
               rd_value[p] = ent_data[tag];
               rd_tag[p]   = tag;
            end
            SRC_BUF_WAIT: begin
               rd_ready[p] = 1'b0;
               rd_tag[p]   = tag;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_ok,
   input logic [IDX_W-1:0] alloc_id,
   input logic             rob_full,
   input logic             ret_vld,
   input logic             flush,
   input logic [CNT_W-1:0] occ,
   input logic [IDX_W-1:0] head,
   input logic [IDX_W-1:0] tail
);
   a_r1_next_slot: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |=> tail == IDX_W'($past(alloc_id) + 1'b1));

   a_r1_occ_track: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> occ == CNT_W'($past(occ) + CNT_W'($past(alloc_ok)) - CNT_W'($past(ret_vld))));

   a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      rob_full |-> !alloc_ok);

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   a_r4_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
      ret_vld |=> head == IDX_W'($past(head) + 1'b1));

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ret_vld && flush));

   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0 && head == '0 && tail == '0));

   a_r11_no_alloc_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ok);
endmodule

bind rob_rename rob_rename_chk #(.DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .alloc_ok(alloc_ok), .alloc_id(alloc_id),
   .rob_full(rob_full), .ret_vld(ret_vld), .flush(flush),
   .occ(occ), .head(head), .tail(tail)
);

// File: tb/test_rob_rename.sv
module test_rob_rename;
   localparam int CLK_PER = 10;
   localparam int DEPTH = 8, AREG_W = 4, DATA_W = 32, PC_W = 32, NUM_RD = 2, NUM_CPL = 2;
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [PC_W-1:0] HPC = 32'h0000_0080;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_req = 1'b0;
   logic [AREG_W-1:0] alloc_dst = '0;
   logic [PC_W-1:0]   alloc_pc = '0;
   logic alloc_ok, rob_full;
   logic [IDX_W-1:0] alloc_id;
   logic [NUM_RD-1:0][AREG_W-1:0] rd_areg = '0;
   logic [NUM_RD-1:0] rd_ready;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_value;
   logic [NUM_RD-1:0][IDX_W-1:0] rd_tag;
   logic [NUM_CPL-1:0] cpl_vld = '0, cpl_exc = '0;
   logic [NUM_CPL-1:0][IDX_W-1:0] cpl_id = '0;
   logic [NUM_CPL-1:0][DATA_W-1:0] cpl_data = '0;
   logic ret_vld, flush;
   logic [AREG_W-1:0] ret_dst;
   logic [DATA_W-1:0] ret_data;
   logic [PC_W-1:0] epc, redirect_pc;

   int checks = 0, errors = 0;
   logic [AREG_W+DATA_W-1:0] sb_q[$];

   always #(CLK_PER/2) clk = ~clk;

   rob_rename #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .PC_W(PC_W),
                .NUM_RD(NUM_RD), .NUM_CPL(NUM_CPL), .HANDLER_PC(HPC)) i_rob_rename (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_dst(alloc_dst),
      .alloc_pc(alloc_pc), .alloc_ok(alloc_ok), .alloc_id(alloc_id), .rob_full(rob_full),
      .rd_areg(rd_areg), .rd_ready(rd_ready), .rd_value(rd_value), .rd_tag(rd_tag),
      .cpl_vld(cpl_vld), .cpl_id(cpl_id), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
      .ret_vld(ret_vld), .ret_dst(ret_dst), .ret_data(ret_data),
      .flush(flush), .epc(epc), .redirect_pc(redirect_pc));

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // operand read on one port; exp_tag < 0 skips the tag compare
   task automatic rd_chk(input string req, input int p, input int areg, input logic rdy,
                         input logic [DATA_W-1:0] val, input int exp_tag);
      rd_areg[p] = AREG_W'(areg);
      #1;
      chk(req, $sformatf("rd_ready r%0d", areg), 64'(rd_ready[p]), 64'(rdy));
      chk(req, $sformatf("rd_value r%0d", areg), 64'(rd_value[p]), 64'(val));
      if (exp_tag >= 0) chk(req, $sformatf("rd_tag r%0d", areg), 64'(rd_tag[p]), 64'(exp_tag));
   endtask

   task automatic alloc(input int dst, input logic [PC_W-1:0] pc, input int exp_id);
      alloc_req = 1'b1; alloc_dst = AREG_W'(dst); alloc_pc = pc;
      #1;
      chk("R1", "alloc_ok", 64'(alloc_ok), 64'd1);
      chk("R1", "alloc_id", 64'(alloc_id), 64'(exp_id));
      tick();
      alloc_req = 1'b0;
   endtask

   task automatic complete(input int p, input int id, input logic [DATA_W-1:0] d,
                           input logic exc);
      cpl_vld[p] = 1'b1; cpl_id[p] = IDX_W'(id); cpl_data[p] = d; cpl_exc[p] = exc;
      tick();
      cpl_vld = '0; cpl_exc = '0;
   endtask

   task automatic expect_ret(input int dst, input logic [DATA_W-1:0] d);
      sb_q.push_back({AREG_W'(dst), d});
   endtask

   // scoreboard monitor: retirements in program order (R4, R5)
   always @(negedge clk) begin
      if (rst_n && ret_vld) begin
         if (sb_q.size() == 0) begin
            chk("R4", "unexpected retire dst", 64'(ret_dst), 64'hFFFF);
         end else begin
            logic [AREG_W+DATA_W-1:0] e;
            e = sb_q.pop_front();
            chk("R5", "ret_dst", 64'(ret_dst), 64'(e[AREG_W+DATA_W-1:DATA_W]));
            chk("R5", "ret_data", 64'(ret_data), 64'(e[DATA_W-1:0]));
         end
      end
   end

   initial begin
      #(CLK_PER * 50000);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      // reset state
      chk("R1", "rob_full after reset", 64'(rob_full), 64'd0);
      chk("R4", "ret_vld after reset", 64'(ret_vld), 64'd0);
      chk("R7", "flush after reset", 64'(flush), 64'd0);
      rd_chk("R8", 0, 5, 1'b1, '0, -1);

      alloc(1, 32'h100, 0);
      alloc(2, 32'h104, 1);
      alloc(1, 32'h108, 2);
      rd_chk("R10", 0, 1, 1'b0, '0, 2);
      rd_chk("R10", 1, 2, 1'b0, '0, 1);

      // younger finishes first
      complete(1, 1, 32'hB0, 1'b0);
      rd_chk("R3", 1, 2, 1'b1, 32'hB0, 1);
      chk("R4", "ret_vld with head pending", 64'(ret_vld), 64'd0);

      expect_ret(1, 32'hA0);
      expect_ret(2, 32'hB0);
      complete(0, 0, 32'hA0, 1'b0);
      tick(); tick();
      chk("R4", "ret_vld with head unfinished", 64'(ret_vld), 64'd0);
      rd_chk("R5", 1, 2, 1'b1, 32'hB0, -1);
      rd_chk("R6", 0, 1, 1'b0, '0, 2);

      expect_ret(1, 32'hC0);
      complete(0, 2, 32'hC0, 1'b0);
      tick();
      rd_chk("R5", 0, 1, 1'b1, 32'hC0, -1);
      chk("R4", "scoreboard drained", 64'(sb_q.size()), 64'd0);

      // fill all slots, ids wrap from 7 to 0
      for (int k = 0; k < DEPTH; k++) alloc(3 + k, 32'h200 + 32'(4 * k), (3 + k) % DEPTH);
      chk("R2", "rob_full", 64'(rob_full), 64'd1);
      alloc_req = 1'b1; alloc_dst = 4'd11; alloc_pc = 32'h2FC;
      #1;
      chk("R2", "alloc_ok when full", 64'(alloc_ok), 64'd0);
      tick();
      alloc_req = 1'b0;
      rd_chk("R2", 0, 11, 1'b1, '0, -1);
      chk("R2", "still full", 64'(rob_full), 64'd1);

      complete(0, 4, 32'h44, 1'b0);
      chk("R4", "younger done waits", 64'(ret_vld), 64'd0);
      rd_chk("R3", 1, 4, 1'b1, 32'h44, 4);

      // fault at head (slot 3, pc 0x200)
      complete(1, 3, 32'h33, 1'b1);
      alloc_req = 1'b1; alloc_dst = 4'd12; alloc_pc = 32'h400;
      #1;
      chk("R7", "flush", 64'(flush), 64'd1);
      chk("R7", "epc", 64'(epc), 64'h200);
      chk("R7", "redirect_pc", 64'(redirect_pc), 64'(HPC));
      chk("R11", "alloc_ok in flush", 64'(alloc_ok), 64'd0);
      tick();
      alloc_req = 1'b0;
      chk("R8", "flush cleared", 64'(flush), 64'd0);
      chk("R8", "not full after flush", 64'(rob_full), 64'd0);
      rd_chk("R8", 0, 3, 1'b1, '0, -1);
      rd_chk("R7", 1, 4, 1'b1, '0, -1);
      rd_chk("R11", 0, 12, 1'b1, '0, -1);
      rd_chk("R8", 1, 1, 1'b1, 32'hC0, -1);
      alloc(0, 32'h300, 0);

      // register zero never mapped
      rd_chk("R9", 0, 0, 1'b1, '0, -1);
      expect_ret(0, 32'h99);
      complete(0, 0, 32'h99, 1'b0);
      tick();
      rd_chk("R9", 1, 0, 1'b1, '0, -1);
      chk("R4", "scoreboard drained at end", 64'(sb_q.size()), 64'd0);
      summary();
   end
endmodule